// File: doc/BRIEF.md
# In-Band Interrupt Response Controller

This block decides how the bus controller answers a target that raises an in-band interrupt. Once the arbitration logic has captured the requester's 7-bit dynamic address and presents it with `req_valid`, the block looks up the reject policy for that address. It gives an ACK or NACK decision. It also says whether the bit-level engine keeps driving the clock for payload bytes. It then finishes the transaction. A rejected requester receives a directed disable-events command with the interrupt-disable bit set. An accepted one is either released at once or followed through its payload. A status record goes to the application when the transaction ends.

There are two lookup modes. In secondary-controller mode (`mode_sec` = 1) a 32-bit reject vector is indexed by a folded hash of the address. In controller-only mode (`mode_sec` = 0) a small device table is searched, and each entry holds its own reject, payload and mandatory-byte flags. In controller-only mode a requester that is not in the table is refused quietly and is always reported.

Top module: `ibi_resp_ctrl`

## Requirements
- R1: With `mode_sec` = 1, the reject bit is `reject_vec[(addr[4:0] + addr[6:5]) mod 32]`. A bit value of 1 gives a NACK (`dec_ack` = 0) and 0 gives an ACK (`dec_ack` = 1).
- R2: With `mode_sec` = 0, the decision comes from the lowest-index table entry that is valid and whose address equals the requester. The entry's reject flag selects NACK (1) or ACK (0).
- R3: When `req_valid` is sampled high while `req_ready` = 1, `dec_valid` pulses high for exactly one cycle, two clock edges later. `req_ready` stays low from the acceptance edge until the transaction ends.
- R4: A NACK to a known requester raises `cmd_valid` on the same edge as the decision, with `cmd_code` = 0x81, `cmd_data` = 0x01, `cmd_restart` = 1 and `cmd_addr` = requester. `cmd_valid` and `cmd_addr` stay unchanged until `cmd_ready` is sampled high.
- R5: After the disable command is accepted, a status record with `sts_ack` = 0 and `sts_unknown` = 0 is pushed on that same edge, but only if `rej_notify` = 1. Otherwise no record is pushed.
- R6: With `mode_sec` = 0, an address that matches no valid entry is NACKed with no command. It gets a status record (`sts_unknown` = 1, `sts_ack` = 0, count 0) on the decision edge, whatever the value of `rej_notify`.
- R7: An ACK with effective payload control sets `dec_payload` = 1. Each `pl_byte` pulse then adds one to the count, which saturates at its maximum. The edge where `pl_end` is high pushes `sts_ack` = 1 with the count, including a `pl_byte` on that same edge.
- R8: An ACK without payload sets `dec_payload` = 0 and pushes `sts_ack` = 1 with count 0 on the decision edge.
- R9: With `mode_sec` = 0, an entry's payload flag takes effect only if its mandatory-byte bit (`tbl_mdb`) is 1. If that bit is 0, the request is ACKed without payload and `sts_cfg_err` = 1.
- R10: With `mode_sec` = 1, `sec_payload_en` alone gives payload control, and `sts_cfg_err` stays 0.
- R11: After reset `req_ready` = 1, `dec_valid`, `cmd_valid` and `sts_valid` are 0, and every table entry is invalid.
- R12: `pl_byte` and `pl_end` have no effect outside the payload phase. `req_valid` has no effect while `req_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sec | input | 1 | 1: reject-vector mode, 0: device-table mode |
| reject_vec | input | 32 | Reject bits, hashed index |
| sec_payload_en | input | 1 | Payload control in reject-vector mode |
| rej_notify | input | 1 | Push status after a rejected known requester |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 3 | Table entry written |
| tbl_valid | input | 1 | Entry valid |
| tbl_addr | input | 7 | Entry dynamic address |
| tbl_reject | input | 1 | Entry reject flag |
| tbl_payload | input | 1 | Entry payload flag |
| tbl_mdb | input | 1 | Entry mandatory-byte capability (device bit 2) |
| req_valid | input | 1 | Captured requester address is present |
| req_addr | input | 7 | Requester dynamic address |
| req_ready | output | 1 | Block idle, request accepted |
| dec_valid | output | 1 | Decision pulse |
| dec_ack | output | 1 | 1 ACK, 0 NACK |
| dec_payload | output | 1 | Keep clocking for payload |
| pl_byte | input | 1 | One payload byte received |
| pl_end | input | 1 | Target ended the payload |
| cmd_valid | output | 1 | Disable command pending |
| cmd_ready | input | 1 | Command engine accepts |
| cmd_code | output | 8 | Command code |
| cmd_addr | output | 7 | Command target address |
| cmd_data | output | 8 | Command data byte |
| cmd_restart | output | 1 | Issue after repeated START |
| sts_valid | output | 1 | Status record push |
| sts_addr | output | 7 | Requester address |
| sts_ack | output | 1 | Request was ACKed |
| sts_unknown | output | 1 | Requester not in table |
| sts_cfg_err | output | 1 | Payload flag set without mandatory byte |
| sts_count | output | 8 | Payload bytes received |

## Verification
The hardest cases to reach are the ones where the block is busy and something else happens at the same time. One is a new request or a stray payload strobe arriving while a disable command is stalled. Another is a payload byte landing on the same edge as the end of the transfer. The stimulus holds `cmd_ready` low for several cycles and fires a second request and `pl_byte`/`pl_end` pulses into that window. It also ends one payload with the byte and end strobes together. A table with duplicate addresses, an invalid entry carrying a live address, and addresses that wrap the hash give the lookup corner cases.

// File: rtl/ibi_resp_pkg.sv
package ibi_resp_pkg;
  localparam logic [7:0] DISEC_CODE   = 8'h81;
  localparam logic [7:0] DISEC_DISINT = 8'h01;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_CMD, ST_PAY} ibi_state_e;

  typedef struct packed {
    logic known;
    logic rej;
    logic pay_req;
    logic mdb_ok;
  } ibi_lookup_t;
endpackage

// File: rtl/ibi_sec_reject.sv
module ibi_sec_reject #(
  parameter int VEC_W  = 32,
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [VEC_W-1:0]  vec,
  output logic              reject
);
  localparam int IDX_W = $clog2(VEC_W);

  logic [IDX_W-1:0] lo, hi, idx;

  always_comb begin
    lo  = addr[IDX_W-1:0];
    hi  = IDX_W'(addr >> IDX_W);
    idx = lo + hi;
    reject = vec[idx];
  end
endmodule

// File: rtl/ibi_dev_table.sv
module ibi_dev_table #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [$clog2(ENTRIES)-1:0] widx,
  input  logic                       w_valid,
  input  logic [ADDR_W-1:0]          w_addr,
  input  logic                       w_reject,
  input  logic                       w_payload,
  input  logic                       w_mdb,
  input  logic [ADDR_W-1:0]          srch_addr,
  output logic                       hit,
  output logic                       hit_reject,
  output logic                       hit_payload,
  output logic                       hit_mdb
);
  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [ENTRIES-1:0] rej_q, pay_q, mdb_q;
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (we) valid_q[widx] <= w_valid;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      addr_q[widx] <= w_addr;
      rej_q[widx]  <= w_reject;
      pay_q[widx]  <= w_payload;
      mdb_q[widx]  <= w_mdb;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (addr_q[g] == srch_addr);
  end

  always_comb begin
    hit = 1'b0;
    hit_reject = 1'b0;
    hit_payload = 1'b0;
    hit_mdb = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        hit_reject = rej_q[i];
        hit_payload = pay_q[i];
        hit_mdb = mdb_q[i];
      end
    end
  end

  assert_hit_valid_R2: assert property (@(posedge clk) disable iff (rst)
    hit |-> (valid_q != '0));
endmodule

// File: rtl/ibi_resp_fsm.sv
module ibi_resp_fsm
  import ibi_resp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sec,
  input  logic              sec_payload_en,
  input  logic              rej_notify,
  input  logic              vec_reject,
  input  logic              tbl_hit,
  input  logic              tbl_reject,
  input  logic              tbl_payload,
  input  logic              tbl_mdb,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              dec_valid,
  output logic              dec_ack,
  output logic              dec_payload,
  input  logic              pl_byte,
  input  logic              pl_end,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              sts_valid,
  output logic              sts_ack,
  output logic              sts_unknown,
  output logic              sts_cfg_err,
  output logic [CNT_W-1:0]  sts_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ibi_state_e  state;
  ibi_lookup_t lk;
  logic        ack_c, pay_go_c, cfg_c;

  always_comb begin
    lk.known   = mode_sec | tbl_hit;
    lk.rej     = mode_sec ? vec_reject : tbl_reject;
    lk.pay_req = mode_sec ? sec_payload_en : tbl_payload;
    lk.mdb_ok  = mode_sec | tbl_mdb;
    ack_c      = lk.known & ~lk.rej;
    pay_go_c   = ack_c & lk.pay_req & lk.mdb_ok;
    cfg_c      = ack_c & lk.pay_req & ~lk.mdb_ok;
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cap_addr    <= '0;
      dec_valid   <= 1'b0;
      dec_ack     <= 1'b0;
      dec_payload <= 1'b0;
      cmd_valid   <= 1'b0;
      sts_valid   <= 1'b0;
      sts_ack     <= 1'b0;
      sts_unknown <= 1'b0;
      sts_cfg_err <= 1'b0;
      sts_count   <= '0;
    end else begin
      dec_valid <= 1'b0;
      sts_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cap_addr <= req_addr;
            state    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          dec_valid   <= 1'b1;
          dec_ack     <= ack_c;
          dec_payload <= pay_go_c;
          sts_ack     <= ack_c;
          sts_unknown <= ~lk.known;
          sts_cfg_err <= cfg_c;
          sts_count   <= '0;
          if (!lk.known) begin
            sts_valid <= 1'b1;
            state     <= ST_IDLE;
          end else if (lk.rej) begin
            cmd_valid <= 1'b1;
            state     <= ST_CMD;
          end else if (pay_go_c) begin
            state <= ST_PAY;
          end else begin
            sts_valid <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_CMD: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            sts_valid <= rej_notify;
            state     <= ST_IDLE;
          end
        end
        ST_PAY: begin
          if (pl_byte && sts_count != CNT_MAX) sts_count <= sts_count + 1'b1;
          if (pl_end) begin
            sts_valid <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_dec_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cap_addr)));
  assert_cmd_after_nack_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> (dec_valid && !dec_ack));
  assert_unknown_nack_R6: assert property (@(posedge clk) disable iff (rst)
    (sts_valid && sts_unknown) |-> (!sts_ack && !cmd_valid));
  assert_payload_needs_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_payload) |-> dec_ack);
  assert_cfg_err_on_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (sts_valid && sts_cfg_err) |-> (sts_ack && !mode_sec));
endmodule

// File: rtl/ibi_resp_ctrl.sv
module ibi_resp_ctrl
  import ibi_resp_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int VEC_W   = 32,
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_sec,
  input  logic [VEC_W-1:0]           reject_vec,
  input  logic                       sec_payload_en,
  input  logic                       rej_notify,
  input  logic                       tbl_we,
  input  logic [$clog2(ENTRIES)-1:0] tbl_idx,
  input  logic                       tbl_valid,
  input  logic [ADDR_W-1:0]          tbl_addr,
  input  logic                       tbl_reject,
  input  logic                       tbl_payload,
  input  logic                       tbl_mdb,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       req_ready,
  output logic                       dec_valid,
  output logic                       dec_ack,
  output logic                       dec_payload,
  input  logic                       pl_byte,
  input  logic                       pl_end,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [7:0]                 cmd_code,
  output logic [ADDR_W-1:0]          cmd_addr,
  output logic [7:0]                 cmd_data,
  output logic                       cmd_restart,
  output logic                       sts_valid,
  output logic [ADDR_W-1:0]          sts_addr,
  output logic                       sts_ack,
  output logic                       sts_unknown,
  output logic                       sts_cfg_err,
  output logic [CNT_W-1:0]           sts_count
);
  logic [ADDR_W-1:0] cap_addr;
  logic vec_reject, t_hit, t_rej, t_pay, t_mdb;

  ibi_sec_reject #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_hash (
    .addr(cap_addr), .vec(reject_vec), .reject(vec_reject)
  );

  ibi_dev_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst(rst), .we(tbl_we), .widx(tbl_idx), .w_valid(tbl_valid),
    .w_addr(tbl_addr), .w_reject(tbl_reject), .w_payload(tbl_payload),
    .w_mdb(tbl_mdb), .srch_addr(cap_addr), .hit(t_hit), .hit_reject(t_rej),
    .hit_payload(t_pay), .hit_mdb(t_mdb)
  );

  ibi_resp_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .mode_sec(mode_sec), .sec_payload_en(sec_payload_en),
    .rej_notify(rej_notify), .vec_reject(vec_reject), .tbl_hit(t_hit),
    .tbl_reject(t_rej), .tbl_payload(t_pay), .tbl_mdb(t_mdb),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .cap_addr(cap_addr), .dec_valid(dec_valid), .dec_ack(dec_ack),
    .dec_payload(dec_payload), .pl_byte(pl_byte), .pl_end(pl_end),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .sts_valid(sts_valid),
    .sts_ack(sts_ack), .sts_unknown(sts_unknown), .sts_cfg_err(sts_cfg_err),
    .sts_count(sts_count)
  );

  assign cmd_code    = DISEC_CODE;
  assign cmd_data    = DISEC_DISINT;
  assign cmd_restart = 1'b1;
  assign cmd_addr    = cap_addr;
  assign sts_addr    = cap_addr;
endmodule

// File: tb/ibi_resp_ctrl_bench.sv
module ibi_resp_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sec = 1'b0, sec_payload_en = 1'b0, rej_notify = 1'b1;
  logic [31:0] reject_vec = '0;
  logic tbl_we = 1'b0, tbl_valid = 1'b0, tbl_reject = 1'b0, tbl_payload = 1'b0, tbl_mdb = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [6:0] tbl_addr = '0, req_addr = '0;
  logic req_valid = 1'b0, pl_byte = 1'b0, pl_end = 1'b0, cmd_ready = 1'b1;
  logic req_ready, dec_valid, dec_ack, dec_payload, cmd_valid, cmd_restart;
  logic [7:0] cmd_code, cmd_data, sts_count;
  logic [6:0] cmd_addr, sts_addr;
  logic sts_valid, sts_ack, sts_unknown, sts_cfg_err;

  always #5 clk = ~clk;

  ibi_resp_ctrl u_ibi_resp_ctrl (
    .clk(clk), .rst(rst), .mode_sec(mode_sec), .reject_vec(reject_vec),
    .sec_payload_en(sec_payload_en), .rej_notify(rej_notify), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_addr(tbl_addr),
    .tbl_reject(tbl_reject), .tbl_payload(tbl_payload), .tbl_mdb(tbl_mdb),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .dec_valid(dec_valid), .dec_ack(dec_ack), .dec_payload(dec_payload),
    .pl_byte(pl_byte), .pl_end(pl_end), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_restart(cmd_restart), .sts_valid(sts_valid),
    .sts_addr(sts_addr), .sts_ack(sts_ack), .sts_unknown(sts_unknown),
    .sts_cfg_err(sts_cfg_err), .sts_count(sts_count)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R11";
  bit started = 0, done = 0;

  // reference model state
  int phase = 0;           // 0 idle, 1 looking, 2 waiting on command, 3 payload
  int m_cap = 0, m_cnt = 0;
  bit m_valid [8];
  int m_addr [8];
  bit m_rej [8], m_pay [8], m_mdb [8];
  bit e_dec = 0, e_ack = 0, e_pay = 0, e_cmd = 0;
  bit e_sts = 0, e_sack = 0, e_unk = 0, e_cfg = 0;
  int e_scnt = 0, e_saddr = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      phase = 0; e_dec = 0; e_cmd = 0; e_sts = 0;
      foreach (m_valid[i]) m_valid[i] = 0;
    end else begin
      e_dec = 0; e_sts = 0;
      if (phase == 3) begin
        if (pl_byte && m_cnt < 255) m_cnt++;
        if (pl_end) begin
          e_sts = 1; e_sack = 1; e_unk = 0; e_scnt = m_cnt; e_saddr = m_cap; phase = 0;
        end
      end else if (phase == 2) begin
        if (cmd_ready) begin
          e_cmd = 0; phase = 0;
          if (rej_notify) begin
            e_sts = 1; e_sack = 0; e_unk = 0; e_cfg = 0; e_scnt = 0; e_saddr = m_cap;
          end
        end
      end else if (phase == 1) begin
        bit known, rej, pr, mdb;
        known = 0; rej = 0; pr = 0; mdb = 0;
        if (mode_sec) begin
          known = 1; rej = reject_vec[((m_cap % 32) + (m_cap / 32)) % 32];
          pr = sec_payload_en; mdb = 1;
        end else begin
          for (int i = 7; i >= 0; i--)
            if (m_valid[i] && m_addr[i] == m_cap) begin
              known = 1; rej = m_rej[i]; pr = m_pay[i]; mdb = m_mdb[i];
            end
        end
        e_dec = 1; e_ack = known && !rej; e_pay = e_ack && pr && mdb;
        e_cfg = e_ack && pr && !mdb; e_saddr = m_cap; e_scnt = 0; m_cnt = 0;
        e_sack = e_ack; e_unk = !known;
        if (!known) begin e_sts = 1; phase = 0; end
        else if (rej) begin e_cmd = 1; phase = 2; end
        else if (e_pay) phase = 3;
        else begin e_sts = 1; phase = 0; end
      end else begin
        if (req_valid) begin m_cap = req_addr; phase = 1; end
      end
      if (tbl_we) begin
        m_valid[tbl_idx] = tbl_valid; m_addr[tbl_idx] = tbl_addr;
        m_rej[tbl_idx] = tbl_reject; m_pay[tbl_idx] = tbl_payload; m_mdb[tbl_idx] = tbl_mdb;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("req_ready", req_ready, phase == 0);
      chk("dec_valid", dec_valid, e_dec);
      if (e_dec) begin
        chk("dec_ack", dec_ack, e_ack);
        chk("dec_payload", dec_payload, e_pay);
      end
      chk("cmd_valid", cmd_valid, e_cmd);
      if (e_cmd) begin
        chk("cmd_code (R4)", cmd_code, 8'h81);
        chk("cmd_data (R4)", cmd_data, 8'h01);
        chk("cmd_restart (R4)", cmd_restart, 1);
        chk("cmd_addr (R4)", cmd_addr, m_cap);
      end
      chk("sts_valid", sts_valid, e_sts);
      if (e_sts) begin
        chk("sts_addr", sts_addr, e_saddr);
        chk("sts_ack", sts_ack, e_sack);
        chk("sts_unknown", sts_unknown, e_unk);
        chk("sts_cfg_err", sts_cfg_err, e_cfg);
        chk("sts_count", sts_count, e_scnt);
      end
    end
  end

  task automatic wait_cy(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(int a);
    @(negedge clk); req_valid = 1'b1; req_addr = 7'(a);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wr(int idx, bit v, int a, bit r, bit p, bit m);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_valid = v; tbl_addr = 7'(a);
    tbl_reject = r; tbl_payload = p; tbl_mdb = m;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic payload(int a, int n);
    do_req(a);
    wait_cy(2);
    for (int i = 0; i < n; i++) begin
      pl_byte = 1'b1; @(negedge clk); pl_byte = 1'b0; @(negedge clk);
    end
    pl_byte = 1'b1; pl_end = 1'b1; @(negedge clk);
    pl_byte = 1'b0; pl_end = 1'b0;
    wait_cy(3);
  endtask

  initial begin
    int addrs [8] = '{7'h00, 7'h1F, 7'h20, 7'h3F, 7'h7F, 7'h61, 7'h45, 7'h12};
    wait_cy(3); rst = 1'b0;
    cur_tag = "R11"; wait_cy(2);
    do_req(7'h10); wait_cy(4);              // empty table after reset: unknown
    cur_tag = "R6"; rej_notify = 1'b0;
    do_req(7'h2A); wait_cy(4); rej_notify = 1'b1;

    cur_tag = "R1"; mode_sec = 1'b1; reject_vec = 32'hA5C3_0F96;
    foreach (addrs[i]) begin do_req(addrs[i]); wait_cy(4); end
    reject_vec = ~32'hA5C3_0F96;
    foreach (addrs[i]) begin do_req(addrs[i]); wait_cy(4); end

    cur_tag = "R10"; reject_vec = '0; sec_payload_en = 1'b1;
    payload(7'h33, 2);
    sec_payload_en = 1'b0; do_req(7'h34); wait_cy(4);

    cur_tag = "R4"; reject_vec = '1; cmd_ready = 1'b0;
    do_req(7'h5A); wait_cy(2);
    cur_tag = "R12";
    do_req(7'h11);                          // ignored while busy
    pl_byte = 1'b1; pl_end = 1'b1; @(negedge clk); pl_byte = 1'b0; pl_end = 1'b0;
    wait_cy(3);
    cur_tag = "R4"; cmd_ready = 1'b1; wait_cy(4);
    cur_tag = "R5"; rej_notify = 1'b0; do_req(7'h66); wait_cy(5); rej_notify = 1'b1;
    cur_tag = "R12";
    pl_byte = 1'b1; pl_end = 1'b1; @(negedge clk); pl_byte = 1'b0; pl_end = 1'b0;
    wait_cy(3);

    cur_tag = "R2"; mode_sec = 1'b0;
    wr(0, 1, 7'h10, 1, 0, 0);
    wr(1, 1, 7'h10, 0, 0, 0);
    wr(2, 1, 7'h22, 0, 1, 1);
    wr(3, 1, 7'h33, 0, 1, 0);
    wr(4, 0, 7'h55, 0, 0, 0);
    wr(5, 1, 7'h45, 0, 0, 1);
    wr(7, 1, 7'h7E, 1, 0, 0);
    do_req(7'h10); wait_cy(5);              // lowest index rejects
    do_req(7'h7E); wait_cy(5);
    cur_tag = "R6"; do_req(7'h55); wait_cy(4);
    cur_tag = "R2"; wr(0, 0, 7'h10, 1, 0, 0);
    do_req(7'h10); wait_cy(4);              // now entry 1 accepts
    cur_tag = "R7"; payload(7'h22, 3);
    payload(7'h22, 0);
    cur_tag = "R8"; do_req(7'h45); wait_cy(4);
    cur_tag = "R9"; do_req(7'h33); wait_cy(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule